// File: doc/BRIEF.md
# Instruction Store Loader with Parity Check

This block lets a host fill a microengine instruction store through a small set of 32-bit registers. Each stored word is 42 bits: a 40-bit instruction plus two even-parity bits. The host writes the index register with its top bit set, which enters programming mode and sets the start entry. It then writes each word in two steps: first the low 32 bits, then the remaining 10 bits. The second step commits the word and moves the index to the next entry. At the end of the store the index wraps to zero. Clearing the top bit of the index register leaves programming mode.

A separate fetch port reads words for execution. Each fetched word has its parity checked. If checking is switched on in the mode register and a parity bit disagrees with its half, a sticky error flag is set. The host clears the flag by writing a one to it. The sequencer that drives the fetch port lies outside this block.

The loader is a three-state machine. ST_IDLE is the state outside programming. ST_WAIT_LO means programming is on and a low half is awaited. ST_WAIT_HI means a low half has been taken and its high half is awaited. The transitions are:
- ENTER: from ST_IDLE to ST_WAIT_LO, on an index write with bit 31 set.
- TAKE_LO: from ST_WAIT_LO or ST_WAIT_HI to ST_WAIT_HI, on a low-half write.
- COMMIT: from ST_WAIT_LO or ST_WAIT_HI to ST_WAIT_LO, on a high-half write.
- RESTART: from either programming state to ST_WAIT_LO, on an index write with bit 31 set.
- LEAVE: from either programming state to ST_IDLE, on an index write with bit 31 clear.

Top module: `cs_loader`

## Requirements
- R1: After reset the block is out of programming mode. The index register (offset 0x000) reads 0, the status register (0x00C) reads 0 and the mode register (0x018) reads 0.
- R2: A write to 0x000 with bit 31 set enters programming mode and loads the index from the low log2(DEPTH) bits. The register then reads bit 31 set with the index in the low bits.
- R3: In programming mode, a write to 0x004 latches all 32 bits as the low half of the word. A write to 0x008 stores {wdata[9:0], low half} at the current index and adds one to the index. Bit 40 of the stored word is parity over bits 19:0, bit 41 is parity over bits 39:20, and bits 39:32 hold the rest of the instruction.
- R4: A commit at entry DEPTH-1 wraps the index to 0, and the index register then reads 0x80000000.
- R5: A write to 0x000 with bit 31 clear ends programming mode and loads the index from the low bits, so writing 0 makes the register read 0.
- R6: While programming mode is off, writes to 0x004 and 0x008 are ignored. The store, the index and the low-half latch keep their values.
- R7: A fetch request on the clock edge makes fetch_valid high in the next cycle, with fetch_word holding the stored word at fetch_addr.
- R8: Parity is even: bit 40 must equal the XOR of bits 19:0, and bit 41 the XOR of bits 39:20. A fetched word that breaks either rule sets the error flag one edge after fetch_valid, provided mode bit 28 is set. The flag shows on perr_flag and on status bit 0.
- R9: While mode bit 28 is clear, a parity mismatch leaves the error flag unchanged.
- R10: The error flag stays set until the host writes status bit 0 as 1. Writing status bit 0 as 0 leaves the flag as it is.
- R11: A high-half write that follows a commit without a new low-half write reuses the last latched low half.
- R12: Reads are combinational. Offset 0x004 returns the low-half latch, 0x008 and any unmapped offset return 0, and the mode register returns only bit 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | AW | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| fetch_en | input | 1 | Fetch request from the sequencer |
| fetch_addr | input | IDX_W | Entry to fetch |
| fetch_valid | output | 1 | Fetched word is valid this cycle |
| fetch_word | output | 42 | Fetched word including parity bits |
| perr_flag | output | 1 | Sticky parity error flag |

## Verification
The assertions assume a single write strobe per cycle with a stable offset. They also assume that a fetch never reads an entry that is being committed in the same cycle and never reads an entry that has not been written. The bench keeps within these limits: its writes come from one task, and it fetches only entries its model has already filled, never while a commit is in flight. The sweep uses a 16-entry store, so every entry is written and the wrap is reached. Every fourth word carries a deliberately wrong low parity bit, so that check-enabled and check-disabled fetches cover both outcomes.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int WORD_W   = 42;
    localparam int INSN_W   = 40;
    localparam int HALF_W   = 20;
    localparam int PROG_BIT = 31;
    localparam int CHK_BIT  = 28;
    localparam int HI_W     = WORD_W - 32;

    localparam logic [9:0] OFS_INDEX  = 10'h000;
    localparam logic [9:0] OFS_LO     = 10'h004;
    localparam logic [9:0] OFS_HI     = 10'h008;
    localparam logic [9:0] OFS_STATUS = 10'h00C;
    localparam logic [9:0] OFS_MODE   = 10'h018;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_LO = 2'd1,
        ST_WAIT_HI = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic idx;
        logic lo;
        logic hi;
        logic status;
        logic mode;
    } wr_sel_t;

endpackage

// File: rtl/cs_ctl.sv
module cs_ctl
    import cs_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int AW    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_wr,
    input  logic [AW-1:0]        csr_addr,
    input  logic [31:0]          csr_wdata,
    input  logic                 err_flag,
    output logic [31:0]          csr_rdata,
    output logic                 commit_en,
    output logic [IDX_W-1:0]     commit_idx,
    output logic [WORD_W-1:0]    commit_word,
    output logic                 chk_en,
    output logic                 err_clr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam int PAD_W = 31 - IDX_W;

    ld_state_e        state_q, state_d;
    wr_sel_t          sel;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      lo_q;
    logic             prog;
    logic             take_lo;

    // address decode
    always_comb begin
        sel        = '0;
        sel.idx    = csr_wr && (csr_addr == AW'(OFS_INDEX));
        sel.lo     = csr_wr && (csr_addr == AW'(OFS_LO));
        sel.hi     = csr_wr && (csr_addr == AW'(OFS_HI));
        sel.status = csr_wr && (csr_addr == AW'(OFS_STATUS));
        sel.mode   = csr_wr && (csr_addr == AW'(OFS_MODE));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel.idx && csr_wdata[PROG_BIT]) state_d = ST_WAIT_LO;
            end
            ST_WAIT_LO, ST_WAIT_HI: begin
                if (sel.idx)     state_d = csr_wdata[PROG_BIT] ? ST_WAIT_LO : ST_IDLE;
                else if (sel.lo) state_d = ST_WAIT_HI;
                else if (sel.hi) state_d = ST_WAIT_LO;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        prog      = 1'b0;
        take_lo   = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT_LO, ST_WAIT_HI: begin
                prog      = 1'b1;
                take_lo   = sel.lo;
                commit_en = sel.hi;
            end
            default: ;
        endcase
    end

    assign commit_idx  = idx_q;
    assign commit_word = {csr_wdata[HI_W-1:0], lo_q};
    assign err_clr     = sel.status && csr_wdata[0];

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            lo_q   <= '0;
            chk_en <= 1'b0;
        end else begin
            if (sel.idx)            idx_q <= csr_wdata[IDX_W-1:0];
            else if (commit_en)     idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            if (take_lo)            lo_q  <= csr_wdata;
            if (sel.mode)           chk_en <= csr_wdata[CHK_BIT];
        end
    end

    // read mux
    always_comb begin
        csr_rdata = '0;
        if (csr_addr == AW'(OFS_INDEX))       csr_rdata = {prog, {PAD_W{1'b0}}, idx_q};
        else if (csr_addr == AW'(OFS_LO))     csr_rdata = lo_q;
        else if (csr_addr == AW'(OFS_STATUS)) csr_rdata = {31'd0, err_flag};
        else if (csr_addr == AW'(OFS_MODE))   csr_rdata = 32'(chk_en) << CHK_BIT;
    end

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !sel.idx && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + 1'b1)); // R3
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && idx_q == LAST_IDX) |=> (idx_q == '0 && state_q == ST_WAIT_LO)); // R4
    AST_LEAVE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.idx && !csr_wdata[PROG_BIT]) |=> (state_q == ST_IDLE)); // R5
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sel.idx) |=> ($stable(idx_q) && $stable(lo_q))); // R6
    AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !commit_en); // R6

endmodule

// File: rtl/cs_store.sv
module cs_store
    import cs_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_word;
        if (rd_en) rd_word <= mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

    AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R7
    AST_FETCH_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R7

endmodule

// File: rtl/cs_parity.sv
module cs_parity
    import cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word,
    input  logic               chk_en,
    input  logic               clr,
    output logic               err_flag
);

    logic bad_lo, bad_hi, hit;

    assign bad_lo = (^word[HALF_W-1:0])      != word[INSN_W];
    assign bad_hi = (^word[INSN_W-1:HALF_W]) != word[INSN_W+1];
    assign hit    = word_valid && chk_en && (bad_lo || bad_hi);

    always_ff @(posedge clk) begin
        if (!rst_n)   err_flag <= 1'b0;
        else if (hit) err_flag <= 1'b1;
        else if (clr) err_flag <= 1'b0;
    end

    AST_ERR_NEEDS_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(chk_en && word_valid)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag); // R10

endmodule

// File: rtl/cs_loader.sv
module cs_loader
    import cs_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [AW-1:0]     csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              fetch_en,
    input  logic [IDX_W-1:0]  fetch_addr,
    output logic              fetch_valid,
    output logic [WORD_W-1:0] fetch_word,
    output logic              perr_flag
);

    logic              commit_en;
    logic [IDX_W-1:0]  commit_idx;
    logic [WORD_W-1:0] commit_word;
    logic              chk_en;
    logic              err_clr;

    cs_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr      (csr_wr),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .err_flag    (perr_flag),
        .csr_rdata   (csr_rdata),
        .commit_en   (commit_en),
        .commit_idx  (commit_idx),
        .commit_word (commit_word),
        .chk_en      (chk_en),
        .err_clr     (err_clr)
    );

    cs_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_en),
        .wr_idx   (commit_idx),
        .wr_word  (commit_word),
        .rd_en    (fetch_en),
        .rd_idx   (fetch_addr),
        .rd_valid (fetch_valid),
        .rd_word  (fetch_word)
    );

    cs_parity u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (fetch_valid),
        .word       (fetch_word),
        .chk_en     (chk_en),
        .clr        (err_clr),
        .err_flag   (perr_flag)
    );

endmodule

// File: tb/cs_loader_tb.sv
module cs_loader_tb;

    localparam int DEPTH = 16;
    localparam int AW    = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        fetch_en = 1'b0;
    logic [3:0]  fetch_addr = '0;
    logic        fetch_valid;
    logic [41:0] fetch_word;
    logic        perr_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model
    logic [41:0] m_mem [DEPTH];
    bit          m_bad [DEPTH];
    bit          m_prog = 0;
    logic [3:0]  m_idx = '0;
    logic [31:0] m_lo = '0;
    bit          m_chk = 0;
    bit          m_flag = 0;

    always #5 clk = ~clk;

    cs_loader #(.DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_en(fetch_en),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .fetch_word(fetch_word), .perr_flag(perr_flag)
    );

    function automatic logic [41:0] mk_word(int i, bit bad);
        logic [39:0] ins;
        logic p_lo, p_hi;
        ins  = {8'(i * 37 + 5), 32'(i * 32'h9E3779B1) ^ 32'h5A5A0F0F};
        p_lo = ^ins[19:0];
        p_hi = ^ins[39:20];
        if (bad) p_lo = ~p_lo;
        return {p_hi, p_lo, ins};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        case (a)
            10'h000: begin m_prog = d[31]; m_idx = d[3:0]; end
            10'h004: if (m_prog) m_lo = d;
            10'h008: if (m_prog) begin
                         m_mem[m_idx] = {d[9:0], m_lo};
                         m_idx = m_idx + 4'd1;
                     end
            10'h00C: if (d[0]) m_flag = 0;
            10'h018: m_chk = d[28];
            default: ;
        endcase
    endtask

    task automatic rd_chk(string req, logic [9:0] a, logic [31:0] exp);
        @(negedge clk);
        csr_addr = a;
        #1 check(req, 64'(csr_rdata), 64'(exp));
    endtask

    task automatic put_word(int i, bit bad);
        logic [41:0] w;
        w = mk_word(i, bad);
        m_bad[m_idx] = bad;
        wr(10'h004, w[31:0]);
        wr(10'h008, {22'd0, w[41:32]});
    endtask

    task automatic do_fetch(string req, int i);
        @(negedge clk);
        fetch_en = 1'b1; fetch_addr = 4'(i);
        @(negedge clk);
        fetch_en = 1'b0;
        check({req, " valid"}, 64'(fetch_valid), 64'd1);
        check({req, " word"}, 64'(fetch_word), 64'(m_mem[i]));
        if (m_chk && m_bad[i]) m_flag = 1;
        @(negedge clk);
        check({req, " flag"}, 64'(perr_flag), 64'(m_flag));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1", 10'h000, 32'h0);
        rd_chk("R1", 10'h00C, 32'h0);
        rd_chk("R1", 10'h018, 32'h0);
        check("R1 flag", 64'(perr_flag), 64'd0);

        // R2 enter programming at 0, R3 fill whole store
        wr(10'h000, 32'h8000_0000);
        rd_chk("R2", 10'h000, 32'h8000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            put_word(i, (i % 4) == 3);
            if (i < DEPTH - 1) rd_chk("R3 index", 10'h000, {1'b1, 27'd0, m_idx});
        end
        // R4 wrap
        rd_chk("R4", 10'h000, 32'h8000_0000);
        rd_chk("R12 lo readback", 10'h004, m_lo);
        rd_chk("R12 hi reads 0", 10'h008, 32'h0);
        rd_chk("R12 unmapped", 10'h040, 32'h0);

        // R2 restart at 5, one word
        wr(10'h000, 32'h8000_0005);
        rd_chk("R2", 10'h000, 32'h8000_0005);
        put_word(21, 0);
        rd_chk("R3", 10'h000, 32'h8000_0006);

        // R11 reuse low half: entries 9 and 10
        wr(10'h000, 32'h8000_0009);
        wr(10'h004, 32'hCAFE_0123);
        wr(10'h008, 32'h0000_0155);
        wr(10'h008, 32'h0000_02AA);
        m_bad[9]  = ((^m_mem[9][19:0])  != m_mem[9][40])  || ((^m_mem[9][39:20])  != m_mem[9][41]);
        m_bad[10] = ((^m_mem[10][19:0]) != m_mem[10][40]) || ((^m_mem[10][39:20]) != m_mem[10][41]);
        rd_chk("R11", 10'h000, 32'h8000_000B);

        // R5 leave programming
        wr(10'h000, 32'h0000_0000);
        rd_chk("R5", 10'h000, 32'h0);

        // R6 ignored writes
        wr(10'h004, 32'h1111_2222);
        wr(10'h008, 32'h0000_03FF);
        rd_chk("R6 lo kept", 10'h004, 32'hCAFE_0123);
        rd_chk("R6 index kept", 10'h000, 32'h0);

        // R7/R9 fetch every entry with checking off
        for (int i = 0; i < DEPTH; i++) do_fetch("R7 R9", i);

        // R8 checking on
        wr(10'h018, 32'h1000_0000);
        rd_chk("R12 mode", 10'h018, 32'h1000_0000);
        do_fetch("R8 good", 0);
        do_fetch("R8 bad", 3);
        rd_chk("R8 status", 10'h00C, 32'h1);
        // R10 sticky and clear
        do_fetch("R10 sticky", 4);
        wr(10'h00C, 32'h0);
        rd_chk("R10 zero write", 10'h00C, 32'h1);
        wr(10'h00C, 32'h1);
        rd_chk("R10 clear", 10'h00C, 32'h0);
        check("R10 pin", 64'(perr_flag), 64'd0);
        for (int i = 0; i < DEPTH; i++) begin
            do_fetch("R8 sweep", i);
            wr(10'h00C, 32'h1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule